// File: doc/BRIEF.md
# Start-Bit Framed Serial Segment Latch

This block receives a two-wire serial stream, a data line and a clock line, along with an active-high enable qualifier. It turns each framed transfer into 35 parallel segment outputs that drive an LED display directly, with no multiplexing. A transfer opens with a logic-one start bit and carries 35 payload bits after it. The framing alone marks where a transfer ends, so no separate load line is needed.

All three serial inputs are brought into the fast system clock domain through two-flop synchronizers. The block finds the rising and falling edges of the serial clock in that domain and samples data on the rising edges. On the rising edge of the 36th accepted clock, the last payload bit and the 34 stored bits are copied into the output latch together. On the falling edge of that clock, the shift stages and the bit counter are cleared. A one-cycle done pulse marks each load, and the current frame position is reported on a status output.

Top module: `seg_frame_rx`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted, the block clears every shift stage, every latched segment output, the bit count and the done pulse. All of them read zero after it is released.
- R2: When the count is zero, a serial clock rising edge whose sampled data is 0 is ignored and the count stays at zero. Only a rising edge with data 1 starts a frame, which sets the count to 1.
- R3: `bit_cnt_o` equals the number of accepted rising edges in the current frame, from 0 to 36. It never exceeds 36.
- R4: The payload bit received k-th after the start bit (k = 1..35) appears on `seg_o[k-1]` once the 36th rising edge is processed. That edge's own bit lands in `seg_o[34]` in the same cycle.
- R5: The falling edge that follows the 36th rising edge returns the count to 0, and the next frame then starts cleanly.
- R6: A frame that stops before its 36th rising edge leaves `seg_o` unchanged and `frame_done_o` low, and the count holds its value.
- R7: While `ser_en_i` is low, serial clock edges are ignored. The count holds and no bit is stored.
- R8: `frame_done_o` is high for exactly one system clock cycle per completed frame, in the cycle the new latch value first appears.
- R9: Between loads `seg_o` does not change. Reloading a pattern identical to the held one leaves every output steady.
- R10: A reset asserted in the middle of a frame clears the latches and the count. The next start bit resumes normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ser_clk_i | input | 1 | External serial clock, asynchronous |
| ser_dat_i | input | 1 | External serial data, asynchronous |
| ser_en_i | input | 1 | Active-high shift enable, asynchronous |
| seg_o | output | 35 | Latched segment outputs; bit k of the payload drives index k-1 |
| frame_done_o | output | 1 | One-cycle pulse on each latch load |
| bit_cnt_o | output | 6 | Accepted rising edges in the current frame (0..36) |

## Verification
Two functions fall in the same system clock cycle. On the 36th rising edge, the final payload bit is sampled and the whole latch is loaded at once, so that bit bypasses the shift stages. The bench provokes this by sending frames whose last bit differs from the bit before it and from the previously held value. It judges the result by checking that `seg_o[34]` shows the new last bit in the same cycle that `frame_done_o` pulses. A reset landing in the middle of a frame is a second collision: it is driven while the shifter holds partial data, and the outputs and count are judged to be zero afterwards.

// File: rtl/seg_frame_pkg.sv
package seg_frame_pkg;
    localparam int PAYLOAD_BITS = 35;
    localparam int FRAME_CLKS   = PAYLOAD_BITS + 1;
    localparam int CNT_W        = $clog2(FRAME_CLKS + 1);

    // raw pin bundle, in synchronizer bit order
    typedef struct packed {
        logic sclk;
        logic sdat;
        logic sen;
    } ser_pins_t;

    // per-cycle event seen by the frame engine
    typedef struct packed {
        logic rise;
        logic fall;
        logic dat;
        logic en;
    } ser_event_t;

    function automatic logic [CNT_W-1:0] cnt_of(input int v);
        return CNT_W'(v);
    endfunction
endpackage

// File: rtl/seg_frame_sync.sv
module seg_frame_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/seg_frame_edge.sv
module seg_frame_edge
    import seg_frame_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ser_pins_t  pins_i,
    output ser_event_t ev_o
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= pins_i.sclk;
    end

    always_comb begin
        ev_o.rise = pins_i.sclk & ~sclk_q;
        ev_o.fall = ~pins_i.sclk & sclk_q;
        ev_o.dat  = pins_i.sdat;
        ev_o.en   = pins_i.sen;
    end
endmodule

// File: rtl/seg_frame_engine.sv
module seg_frame_engine
    import seg_frame_pkg::*;
#(
    parameter int N  = PAYLOAD_BITS,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  ser_event_t    ev_i,
    output logic [N-1:0]  seg_o,
    output logic          done_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST_RISE = CW'(N);
    localparam logic [CW-1:0] FULL      = CW'(N + 1);

    logic [N-2:0]  stage;
    logic [CW-1:0] cnt;
    logic [CW-1:0] wr_idx;

    assign wr_idx = cnt - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            stage  <= '0;
            seg_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (ev_i.en) begin
                if (ev_i.rise) begin
                    if (cnt == '0) begin
                        if (ev_i.dat) cnt <= 1'b1;
                    end else if (cnt < LAST_RISE) begin
                        stage[wr_idx] <= ev_i.dat;
                        cnt           <= cnt + 1'b1;
                    end else if (cnt == LAST_RISE) begin
                        // final bit bypasses the stages into the latch
                        seg_o  <= {ev_i.dat, stage};
                        done_o <= 1'b1;
                        cnt    <= FULL;
                    end
                end else if (ev_i.fall && cnt == FULL) begin
                    stage <= '0;
                    cnt   <= '0;
                end
            end
        end
    end

    assign cnt_o = cnt;

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);
    p_start_needs_one_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && ev_i.en && ev_i.rise && !ev_i.dat) |=> cnt == '0);
    p_enable_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ev_i.en |=> $stable(cnt));
    p_full_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt == FULL) |=> (cnt == FULL || cnt == '0));
endmodule

// File: rtl/seg_frame_rx.sv
module seg_frame_rx
    import seg_frame_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ser_clk_i,
    input  logic                    ser_dat_i,
    input  logic                    ser_en_i,
    output logic [PAYLOAD_BITS-1:0] seg_o,
    output logic                    frame_done_o,
    output logic [CNT_W-1:0]        bit_cnt_o
);
    localparam int PIN_W = $bits(ser_pins_t);

    ser_pins_t  raw_pins, sync_pins;
    ser_event_t ev;

    assign raw_pins = '{sclk: ser_clk_i, sdat: ser_dat_i, sen: ser_en_i};

    seg_frame_sync #(.WIDTH(PIN_W), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_pins),
        .sync_o  (sync_pins)
    );

    seg_frame_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .pins_i (sync_pins),
        .ev_o   (ev)
    );

    seg_frame_engine #(.N(PAYLOAD_BITS), .CW(CNT_W)) u_engine (
        .clk    (clk),
        .rst    (rst),
        .ev_i   (ev),
        .seg_o  (seg_o),
        .done_o (frame_done_o),
        .cnt_o  (bit_cnt_o)
    );

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |=> !frame_done_o);
    p_seg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!frame_done_o && !$past(rst)) |-> $stable(seg_o));
    p_done_at_full_r4: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> bit_cnt_o == cnt_of(FRAME_CLKS));
endmodule

// File: tb/seg_frame_rx_bench.sv
module seg_frame_rx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b1;
    logic [34:0] seg;
    logic        done;
    logic [5:0]  cnt;

    int checks = 0, failures = 0;
    int done_cycles = 0;
    logic        watch_on = 1'b0;
    logic        watch_moved = 1'b0;
    logic [34:0] watch_val = '0;

    always #5 clk = ~clk;

    seg_frame_rx u_seg_frame_rx (
        .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .ser_en_i(ser_en), .seg_o(seg), .frame_done_o(done), .bit_cnt_o(cnt)
    );

    always @(negedge clk) begin
        if (done) done_cycles++;
        if (watch_on && seg !== watch_val) watch_moved = 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ser_rise(input logic d);
        ser_dat = d; wait_n(4);
        ser_clk = 1'b1; wait_n(6);
    endtask

    task automatic ser_fall();
        ser_clk = 1'b0; wait_n(6);
    endtask

    task automatic ser_bit(input logic d);
        ser_rise(d); ser_fall();
    endtask

    task automatic send_frame(input logic [34:0] p);
        ser_bit(1'b1);
        for (int i = 0; i < 35; i++) ser_bit(p[i]);
    endtask

    task automatic pulse_reset();
        rst = 1'b1; wait_n(3); rst = 1'b0; wait_n(2);
    endtask

    task automatic t_reset();
        pulse_reset();
        chk("R1 seg", seg, 0);
        chk("R1 cnt", cnt, 0);
        chk("R1 done", done, 0);
    endtask

    task automatic t_start_zero();
        ser_bit(1'b0); ser_bit(1'b0);
        chk("R2 zero start ignored", cnt, 0);
        ser_bit(1'b1);
        chk("R2 one starts frame", cnt, 1);
        for (int i = 0; i < 35; i++) ser_bit(1'b0);
        chk("R5 cleared after frame", cnt, 0);
    endtask

    task automatic t_full_frame(input logic [34:0] p);
        int d0 = done_cycles;
        ser_bit(1'b1);
        for (int i = 0; i < 34; i++) begin
            ser_bit(p[i]);
            if (i == 9) chk("R3 count mid frame", cnt, 11);
        end
        ser_rise(p[34]);
        chk("R4 mapping incl same-edge last bit", seg, p);
        chk("R4 last bit on seg[34]", seg[34], p[34]);
        chk("R3 count at full", cnt, 36);
        chk("R8 single done pulse", done_cycles - d0, 1);
        ser_fall();
        chk("R5 count back to zero", cnt, 0);
    endtask

    task automatic t_partial();
        logic [34:0] held = seg;
        int d0 = done_cycles;
        ser_bit(1'b1);
        for (int i = 0; i < 20; i++) ser_bit(~held[i]);
        chk("R6 seg unchanged", seg, held);
        chk("R6 count holds", cnt, 21);
        chk("R6 no done", done_cycles - d0, 0);
        pulse_reset();
        chk("R10 seg cleared mid frame", seg, 0);
        chk("R10 count cleared", cnt, 0);
    endtask

    task automatic t_enable_gap(input logic [34:0] p);
        ser_bit(1'b1);
        for (int i = 0; i < 10; i++) ser_bit(p[i]);
        ser_en = 1'b0; wait_n(4);
        ser_bit(~p[10]); ser_bit(~p[10]); ser_bit(1'b1);
        chk("R7 count held with enable low", cnt, 11);
        ser_en = 1'b1; wait_n(4);
        for (int i = 10; i < 35; i++) ser_bit(p[i]);
        chk("R7 gap edges not stored", seg, p);
    endtask

    task automatic t_repeat_same(input logic [34:0] p);
        int d0 = done_cycles;
        watch_val = seg; watch_moved = 1'b0; watch_on = 1'b1;
        send_frame(p);
        watch_on = 1'b0;
        chk("R9 identical reload steady", watch_moved, 0);
        chk("R8 done on identical reload", done_cycles - d0, 1);
    endtask

    initial begin
        wait_n(3);
        t_reset();
        t_start_zero();
        t_full_frame(35'h5_A5A5_A5A5);
        t_full_frame(35'h2_1234_5679);
        t_partial();
        t_full_frame(35'h0_0000_0001);
        t_enable_gap(35'h6_F00F_C3C3);
        t_repeat_same(35'h6_F00F_C3C3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule